// File: doc/BRIEF.md
# Serial Register Port for a Metering Register File

This block is the serial slave side of a metering device's register file. An external host lowers chip select and clocks in one command byte, then one or more data bytes. The command byte says whether the host wants to read or write, and names one of 64 register addresses. Each address has a fixed length of one, two or three bytes. Data moves most significant byte first, and most significant bit first within each byte. The transfer ends once that many bytes have moved.

The port runs entirely on a fast system clock. Serial clock, chip select and data input are each passed through two flops, and the serial clock edges are found from the synchronised copies. Incoming data is taken on the falling serial clock edge. Outgoing data is updated on the rising edge. The output-enable line, which would drive a tristate pad, drops once chip select returns high.

The register file is a small internal array. Address 0x18 holds an 8-bit gain-control register whose fields come out on ports. The analog channels that use those fields are not part of this block.

Top module: `meter_spi_port`

## Requirements
- R1: After reset every register reads 0, `dout_oe_o` is 0, and all gain-field outputs are 0.
- R2: A write command byte has bit 7 = 1, bit 6 = 0 and the address in bits 5:0. The data bytes that follow are stored in that register after the last byte of its length arrives.
- R3: A read command byte has bits 7 and 6 both 0 and the address in bits 5:0. From the rising serial clock edge that ends the command byte, `dout_o` carries the register value MSB first, advancing one bit per rising edge, with `dout_oe_o` high.
- R4: `din_i` is taken at the falling serial clock edge; changes on `din_i` while the serial clock is low have no effect.
- R5: Address 0x18 is 1 byte long, other odd addresses are 3 bytes and other even addresses are 2 bytes. Serial clocks after the last data byte leave the register unchanged.
- R6: Gain register 0x18 fields: bits 1:0 current-channel gain, bit 3 no-load enable, bits 6:5 voltage-channel gain, bit 7 absolute-value summing. Bits 2 and 4 always read 0.
- R7: Chip select going high aborts the transfer. A partly received write leaves the register unchanged, and `dout_oe_o` is 0 within 4 system clocks of chip select rising.
- R8: A command byte with bit 6 = 1 is rejected. Nothing is written and `dout_oe_o` stays 0 until chip select rises.
- R9: Addresses at or above the array depth (32) ignore writes and read as 0.
- R10: `dout_oe_o` is never raised during a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| cs_n_i | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data to the host |
| dout_oe_o | output | 1 | Drive enable for the DOUT pad; low means high impedance |
| gain_cur_o | output | 2 | Current-channel gain select (00 x1, 01 x2, 10 x4) |
| gain_volt_o | output | 2 | Voltage-channel gain select (00 x1, 01 x2, 10 x4) |
| noload_o | output | 1 | No-load enable bit of the gain register |
| abssum_o | output | 1 | Absolute-value summing bit of the gain register |

## Verification
A serial clock edge reaches the control logic three system clocks after the pin changes: two synchroniser flops plus the edge register. Each `dout_o` bit is therefore updated about three clocks after a rising edge, and the bench samples it seven clocks after that edge, just before it drives the falling edge. Register writes and gain-field outputs settle within four clocks of the final falling edge, and the bench inspects them only after chip select has been high for sixteen clocks. The output enable is sampled four clocks after chip select rises, which matches the deadline in R7.

// File: rtl/meter_spi_pkg.sv
package meter_spi_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 24;
  localparam logic [ADDR_W-1:0] GAIN_ADDR = 6'h18;
  localparam logic [7:0] GAIN_KEEP = 8'hEB;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  // byte count of a register, 1..3
  function automatic logic [1:0] reg_len(input logic [ADDR_W-1:0] a);
    if (a == GAIN_ADDR) return 2'd1;
    else if (a[0])      return 2'd3;
    else                return 2'd2;
  endfunction

endpackage

// File: rtl/meter_spi_sync.sv
module meter_spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/meter_spi_ctrl.sv
module meter_spi_ctrl
  import meter_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [1:0]        wr_len,
  output logic              dout,
  output logic              dout_oe
);
  phase_t              phase_q, phase_d;
  logic [2:0]          bit_q, bit_d;
  logic [1:0]          byte_q, byte_d;
  logic [1:0]          len_q, len_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                is_wr_q, is_wr_d;
  logic [7:0]          shin_q, shin_d;
  logic [DATA_W-1:0]   wacc_q, wacc_d;
  logic [DATA_W-1:0]   osh_q, osh_d;
  logic                dout_q, dout_d;
  logic                oe_q, oe_d;
  logic [7:0]          byte_nxt;
  logic [DATA_W-1:0]   rd_aligned;
  logic [1:0]          cmd_len;

  assign byte_nxt = {shin_q[6:0], din_s};
  assign rd_addr  = byte_nxt[ADDR_W-1:0];
  assign cmd_len  = reg_len(byte_nxt[ADDR_W-1:0]);

  // move the register value so its first byte sits at the top
  always_comb begin
    case (cmd_len)
      2'd1:    rd_aligned = rd_data << 16;
      2'd2:    rd_aligned = rd_data << 8;
      default: rd_aligned = rd_data;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    len_d   = len_q;
    addr_d  = addr_q;
    is_wr_d = is_wr_q;
    shin_d  = shin_q;
    wacc_d  = wacc_q;
    osh_d   = osh_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (!cs_act) begin
      phase_d = PH_CMD;
      bit_d   = '0;
      byte_d  = '0;
      shin_d  = '0;
      wacc_d  = '0;
      dout_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      if (sclk_fall && phase_q != PH_DONE) begin
        shin_d = byte_nxt;
        bit_d  = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (phase_q == PH_CMD) begin
            addr_d  = byte_nxt[ADDR_W-1:0];
            is_wr_d = byte_nxt[7];
            len_d   = cmd_len;
            byte_d  = '0;
            if (byte_nxt[6]) begin
              phase_d = PH_DONE;
            end else begin
              phase_d = PH_DATA;
              if (!byte_nxt[7]) begin
                oe_d  = 1'b1;
                osh_d = rd_aligned;
              end
            end
          end else begin
            wacc_d = {wacc_q[DATA_W-9:0], byte_nxt};
            byte_d = byte_q + 2'd1;
            if (byte_q == len_q - 2'd1) begin
              phase_d = PH_DONE;
              wr_en   = is_wr_q;
            end
          end
        end
      end
      if (sclk_rise && phase_q == PH_DATA && !is_wr_q) begin
        dout_d = osh_q[DATA_W-1];
        osh_d  = {osh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bit_q   <= '0;
      byte_q  <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      is_wr_q <= 1'b0;
      shin_q  <= '0;
      wacc_q  <= '0;
      osh_q   <= '0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      is_wr_q <= is_wr_d;
      shin_q  <= shin_d;
      wacc_q  <= wacc_d;
      osh_q   <= osh_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = {wacc_q[DATA_W-9:0], byte_nxt};
  assign wr_len  = len_q;
  assign dout    = dout_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/meter_spi_regs.sv
module meter_spi_regs
  import meter_spi_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_len,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        gain
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DATA_W-1:0] mem [NREG];
  logic [NREG-1:0]   we;
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] len_mask;

  always_comb begin
    case (wr_len)
      2'd1:    len_mask = 24'h0000FF;
      2'd2:    len_mask = 24'h00FFFF;
      default: len_mask = 24'hFFFFFF;
    endcase
    wval = wr_data & len_mask;
    if (wr_addr == GAIN_ADDR) wval = wval & {16'h0, GAIN_KEEP};
  end

  for (genvar i = 0; i < NREG; i++) begin : g_row
    assign we[i] = wr_en && (int'(wr_addr) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[i] <= '0;
      else if (we[i]) mem[i] <= wval;
    end
  end

  always_comb begin
    if (int'(rd_addr) < NREG) rd_data = mem[rd_addr[IDX_W-1:0]];
    else                      rd_data = '0;
  end

  assign gain = mem[GAIN_ADDR[IDX_W-1:0]][7:0];
endmodule

// File: rtl/meter_spi_port.sv
module meter_spi_port
  import meter_spi_pkg::*;
#(
  parameter int NREG = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       din_i,
  output logic       dout_o,
  output logic       dout_oe_o,
  output logic [1:0] gain_cur_o,
  output logic [1:0] gain_volt_o,
  output logic       noload_o,
  output logic       abssum_o
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, din_s;
  logic              sclk_q;
  logic              sclk_rise, sclk_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [1:0]        wr_len;
  logic              wr_en;
  logic [7:0]        gain;

  meter_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_i, cs_n_i, din_i}), .q(pins_s)
  );
  assign {sclk_s, cs_n_s, din_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  meter_spi_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_act(~cs_n_s), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .din_s(din_s), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_len(wr_len),
    .dout(dout_o), .dout_oe(dout_oe_o)
  );

  meter_spi_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_len(wr_len), .rd_addr(rd_addr), .rd_data(rd_data),
    .gain(gain)
  );

  assign gain_cur_o  = gain[1:0];
  assign noload_o    = gain[3];
  assign gain_volt_o = gain[6:5];
  assign abssum_o    = gain[7];
endmodule

// File: rtl/meter_spi_port_chk.sv
module meter_spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_i,
  input logic dout_o,
  input logic dout_oe_o,
  input logic sclk_rise,
  input logic wr_en,
  input logic [1:0] gain_volt_o
);
  // R7: pad released once chip select has stayed high
  a_r7_release_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !dout_oe_o);

  // R10: a committing write never coincides with a driven pad
  a_r10_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !dout_oe_o);

  // R2: one commit per transfer end, never two cycles running
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R3: data only moves after a rising serial edge
  a_r3_dout_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe_o && $past(dout_oe_o) && !$past(sclk_rise)) |-> $stable(dout_o));

  // R6: the voltage gain field changes only when a write commits
  a_r6_gain_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(gain_volt_o));
endmodule

bind meter_spi_port meter_spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .dout_o(dout_o),
  .dout_oe_o(dout_oe_o), .sclk_rise(sclk_rise), .wr_en(wr_en),
  .gain_volt_o(gain_volt_o)
);

// File: tb/tb_meter_spi_port.sv
module tb_meter_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b1;
  logic dout_o, dout_oe_o, noload_o, abssum_o;
  logic [1:0] gain_cur_o, gain_volt_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  logic [23:0] act_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  meter_spi_port dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .gain_cur_o(gain_cur_o),
    .gain_volt_o(gain_volt_o), .noload_o(noload_o), .abssum_o(abssum_o)
  );

  // monitor: compares results as they are produced
  always @(negedge clk) begin
    while (act_q.size() > 0) begin
      logic [23:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, a, e);
      end
    end
  end

  task automatic post(input string t, input logic [23:0] act, input logic [23:0] exp);
    tag_q.push_back(t);
    exp_q.push_back(exp);
    act_q.push_back(act);
  endtask

  // one transfer; stop_at >= 0 aborts before that bit
  task automatic xfer(input logic [7:0] cmd, input int nb, input logic [23:0] wd,
                      input int stop_at, output logic [23:0] rd, output logic oe_seen,
                      output logic oe_pre, output logic oe_post);
    int total;
    logic b;
    total = 8 + 8 * nb;
    rd = '0;
    oe_seen = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      if (stop_at >= 0 && i == stop_at) break;
      b = (i < 8) ? cmd[7-i] : wd[8*nb-1-(i-8)];
      din = b;
      repeat (7) @(negedge clk);
      if (i >= 8) rd = {rd[22:0], dout_o};
      if (i >= 8) oe_seen = oe_seen | dout_oe_o;
      @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      din = ~b;  // R4: value after the falling edge must not matter
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (8) @(negedge clk);
    oe_pre = dout_oe_o;
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    oe_post = dout_oe_o;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input string t, input logic [5:0] a, input int nb, input logic [23:0] d);
    logic [23:0] r;
    logic s, p, q;
    xfer({2'b10, a}, nb, d, -1, r, s, p, q);
    post({t, " write never drives DOUT (R10)"}, {23'd0, s | p}, 24'd0);
  endtask

  task automatic rd_chk(input string t, input logic [5:0] a, input int nb, input logic [23:0] e);
    logic [23:0] r;
    logic s, p, q;
    xfer({2'b00, a}, nb, 24'd0, -1, r, s, p, q);
    post(t, r, e);
    post({t, " oe during read (R3)"}, {23'd0, s}, 24'd1);
    post({t, " oe released (R7)"}, {23'd0, q}, 24'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    logic s, p, q;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    post("R1 oe after reset", {23'd0, dout_oe_o}, 24'd0);
    post("R1 gain fields after reset",
         {18'd0, abssum_o, gain_volt_o, noload_o, gain_cur_o}, 24'd0);
    rd_chk("R1 reg 0x05 after reset", 6'h05, 3, 24'd0);
    rd_chk("R1 gain reg after reset", 6'h18, 1, 24'd0);

    wr("R2", 6'h05, 3, 24'hA5C33C);
    rd_chk("R2 R3 R4 three-byte readback", 6'h05, 3, 24'hA5C33C);
    wr("R5", 6'h06, 2, 24'h001234);
    rd_chk("R5 two-byte readback", 6'h06, 2, 24'h001234);
    wr("R5", 6'h0B, 3, 24'h0F0F81);
    rd_chk("R5 odd address readback", 6'h0B, 3, 24'h0F0F81);

    wr("R6", 6'h18, 1, 24'h0000FF);
    rd_chk("R6 reserved bits read 0", 6'h18, 1, 24'h0000EB);
    post("R6 field ports all set",
         {18'd0, abssum_o, gain_volt_o, noload_o, gain_cur_o}, {18'd0, 6'b111111});
    wr("R6", 6'h18, 1, 24'h000041);
    post("R6 current gain field", {22'd0, gain_cur_o}, 24'd1);
    post("R6 voltage gain field", {22'd0, gain_volt_o}, 24'd2);
    post("R6 no-load and abs bits", {22'd0, noload_o, abssum_o}, 24'd0);

    // R5: extra byte after a 1-byte register is ignored
    xfer(8'h98, 2, 24'h0022FF, -1, r, s, p, q);
    rd_chk("R5 surplus byte ignored", 6'h18, 1, 24'h000022);
    post("R5 voltage field after surplus byte", {22'd0, gain_volt_o}, 24'd1);

    // R7: partial write discarded
    xfer(8'h86, 2, 24'h00ABCD, 20, r, s, p, q);
    rd_chk("R7 partial write discarded", 6'h06, 2, 24'h001234);
    // R7: abort a read, pad released within 4 clocks
    xfer(8'h05, 3, 24'd0, 14, r, s, p, q);
    post("R7 oe high before abort", {23'd0, p}, 24'd1);
    post("R7 oe low after abort", {23'd0, q}, 24'd0);

    // R8: bit 6 set
    xfer(8'hC6, 2, 24'h00FFFF, -1, r, s, p, q);
    post("R8 rejected write no drive", {23'd0, s | p}, 24'd0);
    rd_chk("R8 rejected write ignored", 6'h06, 2, 24'h001234);
    xfer(8'h45, 3, 24'd0, -1, r, s, p, q);
    post("R8 rejected read no drive", {23'd0, s | p}, 24'd0);

    // R9: outside the array
    wr("R9", 6'h30, 2, 24'h00BEEF);
    rd_chk("R9 out-of-range reads 0", 6'h30, 2, 24'd0);
    rd_chk("R9 in-range reg untouched", 6'h05, 3, 24'hA5C33C);

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule